// File: doc/BRIEF.md
# Data-Bus Tenure Master Control

This block decides when a bus master takes ownership of a shared data bus and which of its pending data tenures it serves next. Pending tenures are pushed into a small queue in the order their address tenures completed. Each entry records whether the transfer is a read or a write, and whether it is a single beat or a burst. The block watches a data-bus grant input, a busy line that reflects other masters, and a write-only override. It raises its own busy output for the full duration of the tenure it owns, and reports the kind of that tenure so the datapath can steer the transfer.

With the override negated, tenures are served strictly oldest first, and a start needs a qualified grant. When the override is asserted, the oldest pending write jumps ahead of any older pipelined reads. This lets a write that the system needs urgently leave before reads whose addresses went out earlier. When no write is pending, the override only matters when a grant comes with it, and a grant alone already serves the oldest read.

Top module: `dbus_tenure_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, busy_o and last_beat_o are 0, enq_ready_o is 1 and the queue is empty.
- R2: A tenure starts only on a clock edge where ext_busy_i is 0 and busy_o is 0. A grant_i or wr_only_i seen while ext_busy_i is 1 starts nothing.
- R3: With wr_only_i at 0, a grant_i sampled with ext_busy_i at 0 and a non-empty queue starts the oldest queued tenure, whether it is a read or a write.
- R4: With wr_only_i at 1 and at least one write queued, the block starts the oldest queued write when the bus is free, even with grant_i at 0 and even if older reads are queued. The reads keep their relative order.
- R5: With wr_only_i at 1, no write queued and grant_i at 0, no tenure starts and the queue is unchanged.
- R6: With wr_only_i at 1, grant_i at 1 and only reads queued, the oldest read starts.
- R7: busy_o rises on the cycle after the start edge. It stays high for exactly 1 cycle for a single-beat tenure (enq_burst_i = 0) and BURST_BEATS cycles (4 by default) for a burst (enq_burst_i = 1). last_beat_o marks its final cycle, and busy_o is low on the cycle after.
- R8: While busy_o is 1, cur_write_o (1 = write) and cur_burst_o (1 = burst) give the kind of the tenure being served, and they hold steady for that whole tenure.
- R9: enq_ready_o is 1 exactly when fewer than DEPTH entries are queued. An enq_valid_i sampled with enq_ready_o at 0 is dropped, and accepted entries keep arrival order after an entry is removed from the middle of the queue.
- R10: A grant_i while the queue is empty starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Data-bus grant from the arbiter |
| wr_only_i | input | 1 | Write-only override |
| ext_busy_i | input | 1 | Data bus held by another master |
| enq_valid_i | input | 1 | Push a pending data tenure |
| enq_write_i | input | 1 | Pushed tenure is a write (1) or read (0) |
| enq_burst_i | input | 1 | Pushed tenure is a burst (1) or single beat (0) |
| enq_ready_o | output | 1 | Queue has room |
| busy_o | output | 1 | This master owns the data bus |
| cur_write_o | output | 1 | Current tenure is a write |
| cur_burst_o | output | 1 | Current tenure is a burst |
| last_beat_o | output | 1 | Final beat of the current tenure |

## Verification
The bench places writes behind older reads and raises the override without a grant. A design that ignored the override would sit idle. A design that took the head entry would serve a read, and one that removed the wrong slot would then serve the remaining reads out of order. The bench also asserts grant and override while the bus is held by another master, and raises the override with only reads queued. A design that skipped grant qualification, or that let the override start a read alone, would raise busy there. Burst and single-beat tenures are run back to back under a held grant, which catches an off-by-one in the beat count or a missing idle cycle. Pushes into a full queue catch a design that overwrote an entry.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef struct packed {
    logic wr;
    logic burst;
  } dbt_op_t;
endpackage

// File: rtl/dbt_queue.sv
module dbt_queue
  import dbt_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  dbt_op_t               push_op_i,
  input  logic                  pop_i,
  input  logic [IW-1:0]         pop_idx_i,
  output dbt_op_t [DEPTH-1:0]   ops_o,
  output logic [CW-1:0]         cnt_o,
  output logic                  full_o
);
  dbt_op_t [DEPTH-1:0] ent_q, ent_d;
  logic [CW-1:0]       cnt_q, cnt_pop;
  logic                push_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign cnt_pop = cnt_q - CW'(pop_i);

  // compacted storage: slots above the popped one slide down, push lands at tail
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    dbt_op_t shifted;
    logic    slide;
    assign slide = pop_i && (IW'(i) >= pop_idx_i);
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = slide ? ent_q[i+1] : ent_q[i];
    end else begin : g_top
      assign shifted = slide ? dbt_op_t'('0) : ent_q[i];
    end
    assign ent_d[i] = (push_ok && (cnt_pop == CW'(i))) ? push_op_i : shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_d;
      cnt_q <= cnt_pop + CW'(push_ok);
    end
  end

  assign ops_o = ent_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbt_pick.sv
module dbt_pick
  import dbt_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  dbt_op_t [DEPTH-1:0] ops_i,
  input  logic [CW-1:0]       cnt_i,
  output logic                wr_found_o,
  output logic [IW-1:0]       wr_idx_o
);
  logic [DEPTH-1:0] wr_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign wr_hit[i] = ops_i[i].wr && (CW'(i) < cnt_i);
  end

  always_comb begin
    wr_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (wr_hit[i]) wr_idx_o = IW'(i);
    end
  end

  assign wr_found_o = |wr_hit;
endmodule

// File: rtl/dbt_beat_ctr.sv
module dbt_beat_ctr #(
  parameter int unsigned BURST_BEATS = 4,
  localparam int unsigned BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic burst_i,
  output logic busy_o,
  output logic last_o
);
  logic          busy_q;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      left_q <= burst_i ? BW'(BURST_BEATS - 1) : '0;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (left_q == '0);
endmodule

// File: rtl/dbus_tenure_ctrl.sv
module dbus_tenure_ctrl
  import dbt_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic wr_only_i,
  input  logic ext_busy_i,
  input  logic enq_valid_i,
  input  logic enq_write_i,
  input  logic enq_burst_i,
  output logic enq_ready_o,
  output logic busy_o,
  output logic cur_write_o,
  output logic cur_burst_o,
  output logic last_beat_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  dbt_op_t [DEPTH-1:0] ops;
  logic [CW-1:0]       cnt;
  logic                full, wr_found, busy, last;
  logic [IW-1:0]       wr_idx, sel_idx;
  logic                bus_free, take_wr, take_ord, start;
  dbt_op_t             sel_op, cur_q;

  dbt_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i    (enq_valid_i),
    .push_op_i ({enq_write_i, enq_burst_i}),
    .pop_i     (start),
    .pop_idx_i (sel_idx),
    .ops_o     (ops),
    .cnt_o     (cnt),
    .full_o    (full)
  );

  dbt_pick #(.DEPTH(DEPTH)) u_pick (
    .ops_i      (ops),
    .cnt_i      (cnt),
    .wr_found_o (wr_found),
    .wr_idx_o   (wr_idx)
  );

  // qualified: own bus idle and no other master holding it
  assign bus_free = !busy && !ext_busy_i;
  // override promotes oldest write without needing a grant
  assign take_wr  = bus_free && wr_only_i && wr_found;
  assign take_ord = bus_free && grant_i && (cnt != '0) && !take_wr;
  assign start    = take_wr || take_ord;
  assign sel_idx  = take_wr ? wr_idx : '0;
  assign sel_op   = ops[sel_idx];

  dbt_beat_ctr #(.BURST_BEATS(BURST_BEATS)) u_beat (
    .clk_i, .rst_ni,
    .load_i  (start),
    .burst_i (sel_op.burst),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_q <= '0;
    else if (start) cur_q <= sel_op;
  end

  assign enq_ready_o = !full;
  assign busy_o      = busy;
  assign last_beat_o = last;
  assign cur_write_o = cur_q.wr;
  assign cur_burst_o = cur_q.burst;
endmodule

// File: rtl/dbus_tenure_ctrl_chk.sv
module dbus_tenure_ctrl_chk #(
  parameter int unsigned BURST_BEATS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic wr_only_i,
  input logic ext_busy_i,
  input logic busy_o,
  input logic cur_write_o,
  input logic cur_burst_o,
  input logic last_beat_o
);
  localparam int unsigned RW = $clog2(BURST_BEATS + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_HOLD_UNTIL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_beat_o |=> busy_o);  // R7
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o |=> !busy_o);  // R7
  AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < RW'(BURST_BEATS));  // R7
  AST_BURST_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o && cur_burst_o |-> run_q == RW'(BURST_BEATS - 1));  // R7
  AST_SINGLE_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cur_burst_o |-> last_beat_o);  // R7
  AST_NO_START_EXT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && ext_busy_i |=> !busy_o);  // R2
  AST_NO_START_UNASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !grant_i && !wr_only_i |=> !busy_o);  // R5
  AST_KIND_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$rose(busy_o) |-> $stable(cur_write_o) && $stable(cur_burst_o));  // R8
endmodule

bind dbus_tenure_ctrl dbus_tenure_ctrl_chk #(.BURST_BEATS(BURST_BEATS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant_i),
  .wr_only_i   (wr_only_i),
  .ext_busy_i  (ext_busy_i),
  .busy_o      (busy_o),
  .cur_write_o (cur_write_o),
  .cur_burst_o (cur_burst_o),
  .last_beat_o (last_beat_o)
);

// File: tb/dbus_tenure_ctrl_test.sv
module dbus_tenure_ctrl_test;
  localparam int DEPTH = 4;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant = 1'b0, wr_only = 1'b0, ext_busy = 1'b0;
  logic enq_v = 1'b0, enq_w = 1'b0, enq_b = 1'b0;
  logic enq_ready, busy, cur_w, cur_b, last;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string ph = "R1";

  always #4 clk = ~clk;

  dbus_tenure_ctrl #(.DEPTH(DEPTH), .BURST_BEATS(BEATS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant), .wr_only_i(wr_only),
    .ext_busy_i(ext_busy), .enq_valid_i(enq_v), .enq_write_i(enq_w),
    .enq_burst_i(enq_b), .enq_ready_o(enq_ready), .busy_o(busy),
    .cur_write_o(cur_w), .cur_burst_o(cur_b), .last_beat_o(last)
  );

  // behavioural reference: bit1 = write, bit0 = burst
  bit [1:0] mq[$];
  bit       m_busy = 1'b0;
  int       m_left = 0;
  bit [1:0] m_cur = 2'b00;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete();
      m_busy = 1'b0;
      m_left = 0;
      m_cur  = 2'b00;
    end else begin
      int  old_n;
      int  pick;
      bit  acc;
      old_n = mq.size();
      acc   = enq_v && (old_n < DEPTH);
      if (m_busy) begin
        if (m_left == 0) m_busy = 1'b0;
        else             m_left--;
      end else if (!ext_busy && old_n > 0) begin
        int wi;
        wi = -1;
        for (int k = old_n - 1; k >= 0; k--) if (mq[k][1]) wi = k;
        pick = -1;
        if (wr_only && wi >= 0) pick = wi;
        else if (grant)         pick = 0;
        if (pick >= 0) begin
          m_cur  = mq[pick];
          mq.delete(pick);
          m_busy = 1'b1;
          m_left = m_cur[0] ? BEATS - 1 : 0;
        end
      end
      if (acc) mq.push_back({enq_w, enq_b});
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(busy, m_busy, ph, "busy");
      chk(last, m_busy && m_left == 0, ph, "last_beat");
      chk(enq_ready, mq.size() < DEPTH, "R9", "enq_ready");
      if (m_busy) begin
        chk(cur_w, m_cur[1], "R8", "cur_write");
        chk(cur_b, m_cur[0], "R8", "cur_burst");
      end
    end
  endtask

  task automatic push(input logic w, input logic b);
    enq_v = 1'b1; enq_w = w; enq_b = b;
    cyc();
    enq_v = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        fails++;
        $display("FAIL watchdog act=%0d exp=<20000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk(busy, 1'b0, "R1", "busy in reset");
    chk(enq_ready, 1'b1, "R1", "ready in reset");
    chk(last, 1'b0, "R1", "last in reset");
    cyc(2);
    rst_ni = 1'b1;
    cyc();
    chk(busy, 1'b0, "R1", "busy after reset");

    // R10: grant with empty queue
    ph = "R10";
    grant = 1'b1;
    cyc(4);
    grant = 1'b0;

    // R2: demand while another master holds the bus
    ph = "R2";
    push(1'b0, 1'b0);
    push(1'b0, 1'b1);
    push(1'b1, 1'b0);
    ext_busy = 1'b1; grant = 1'b1; wr_only = 1'b1;
    cyc(5);
    wr_only = 1'b0;

    // R3 / R7: in-order service with held grant, single and burst back to back
    ph = "R3";
    ext_busy = 1'b0;
    cyc(3);
    ph = "R7";
    cyc(10);
    grant = 1'b0;

    // R4: override promotes writes behind older reads, no grant
    ph = "R4";
    push(1'b0, 1'b0);
    push(1'b0, 1'b1);
    push(1'b1, 1'b1);
    push(1'b1, 1'b0);
    wr_only = 1'b1;
    cyc(10);

    // R5: override with only reads queued and no grant
    ph = "R5";
    cyc(5);

    // R6: override plus grant serves oldest read
    ph = "R6";
    grant = 1'b1;
    cyc(10);
    grant = 1'b0; wr_only = 1'b0;

    // R9: overflow dropped, order kept after middle removal
    ph = "R9";
    push(1'b0, 1'b0);
    push(1'b1, 1'b0);
    push(1'b0, 1'b1);
    push(1'b1, 1'b1);
    push(1'b0, 1'b0);
    push(1'b0, 1'b1);
    cyc(2);
    wr_only = 1'b1;
    cyc();
    wr_only = 1'b0;
    cyc(3);
    grant = 1'b1;
    push(1'b1, 1'b0);
    cyc(14);
    grant = 1'b0;
    cyc(3);
    chk(enq_ready, 1'b1, "R9", "queue drained");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule